// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes one floating-point result held in a wide working form (a class code, a sign, an unbiased exponent, a significand carrying its leading one together with a guard bit and a round bit, and a separate sticky bit) and forms the final 32-bit single-precision word. The significand is rounded under a 2-bit mode. The exponent is then rebiased. Values that fall below the normal range follow a gradual-underflow path. Values that exceed it saturate to infinity or to the largest finite value, depending on the mode and the sign.

Each accepted input gives one registered result a single clock later. The result carries four per-result flags: inexact, underflow, overflow and operand error. The same flags are accumulated into a sticky status register, which the surrounding unit can clear.

Top module: `sp_packer`

## Requirements
- R1: A result appears on `out_word`/`out_flags` with `out_valid` high exactly one clock after `in_valid` is sampled high. Reset clears `out_valid`, `out_word`, `out_flags` and `status`.
- R2: For class 3 (NaN), the word is the input sign, exponent field 255, and fraction = `in_sig[24:2]`. No flag is raised.
- R3: Class 2 (infinity) packs as sign, exponent field 255, zero fraction. Class 0 (zero) packs as the sign bit alone. Neither raises a flag, whatever the mode.
- R4: For class 1 (number) with biased exponent `in_exp+127` of 1 or more, the word is sign, the biased exponent and the 23 rounded fraction bits. Modes are encoded as 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity.
- R5: Inexact (flag bit 0) is set for a number when guard, round, sticky, or any bit shifted out on the underflow path is nonzero.
- R6: When rounding carries the significand to 2.0, the exponent field rises by one and the fraction becomes zero.
- R7: A biased exponent of 0 or less shifts the significand right by 1 minus the biased exponent (excess bits fold into sticky). The result is rounded and emitted with exponent field 0, and underflow (flag bit 1) is set.
- R8: If rounding on the underflow path reaches 2^23, the word has exponent field 1 and zero fraction, and underflow stays set.
- R9: A final exponent of 255 or more sets overflow (bit 2), inexact (bit 0) and operand error (bit 3).
- R10: On overflow, infinity is produced in mode 0, in mode 2 for negative values and in mode 3 for positive values. Otherwise the result is exponent 254 with an all-ones fraction.
- R11: `status` ORs in each result's flags. A cycle with `clr_status` high loads `status` with only the flags of the result formed in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operand present |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_sig | input | 26 | Leading one [25], fraction [24:2], guard [1], round [0] |
| in_sticky | input | 1 | OR of all lower discarded bits |
| rnd_mode | input | 2 | Rounding mode |
| clr_status | input | 1 | Clear the sticky status register |
| out_valid | output | 1 | Result valid |
| out_word | output | 32 | Packed single-precision word |
| out_flags | output | 4 | {operand error, overflow, underflow, inexact} of this result |
| status | output | 4 | Accumulated flags, same bit order |

## Verification
Two pairs of functions can act in the same cycle. A rounding carry can push the exponent from 254 to 255, so the carry and the overflow saturation happen together. A status clear can arrive in the same cycle as a flagged result. The bench provokes the first with an all-ones fraction at the top exponent and a set guard bit. It expects infinity and the full overflow flag set, with no finite word. It provokes the second by raising the clear together with an underflowing inexact input. It expects the status to equal exactly that input's flags, with nothing left over from earlier results.

// File: rtl/sp_pkg.sv
// Shared types for the single-precision packer.
// Assumes: class and mode codes are fixed by the surrounding unit.
package sp_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } val_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_TOZERO  = 2'd1,
        RM_DOWN    = 2'd2,
        RM_UP      = 2'd3
    } rnd_mode_e;

    // Flag bit positions
    localparam int FLG_INEX  = 0;
    localparam int FLG_UNFL  = 1;
    localparam int FLG_OVFL  = 2;
    localparam int FLG_OPERR = 3;
    localparam int FLG_W     = 4;

endpackage

// File: rtl/sp_align.sv
// Right-shifts the working significand for the underflow path.
// Every bit shifted out is folded into the sticky output.
// Assumes: shift amounts at or above SIG_W push everything into sticky.
module sp_align #(
    parameter int SIG_W = 26,
    parameter int SH_W  = 5
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic             sticky_in,
    input  logic [SH_W-1:0]  shamt,
    output logic [SIG_W-1:0] sig_out,
    output logic             sticky_out
);
    logic [SIG_W-1:0] lost_mask;

    // Build the mask of positions that fall off the bottom.
    always_comb begin
        if (int'(shamt) >= SIG_W)
            lost_mask = {SIG_W{1'b1}};
        else
            lost_mask = ~({SIG_W{1'b1}} << shamt);
    end

    // Shift and collect the discarded bits.
    always_comb begin
        sig_out    = (int'(shamt) >= SIG_W) ? '0 : (sig_in >> shamt);
        sticky_out = sticky_in | (|(sig_in & lost_mask));
    end
endmodule

// File: rtl/sp_round.sv
// Rounds an integer significand using guard, round and sticky bits.
// The result is one bit wider, so a carry-out shows as the top bit.
// Assumes: the mode encoding from sp_pkg.
module sp_round
    import sp_pkg::*;
#(
    parameter int MANT_W = 24
) (
    input  logic [MANT_W-1:0] mant,
    input  logic              guard,
    input  logic              rnd,
    input  logic              sticky,
    input  logic              sign,
    input  logic [1:0]        mode,
    output logic [MANT_W:0]   result,
    output logic              inexact
);
    logic bump;

    // Decide whether to add one unit in the last place.
    always_comb begin
        inexact = guard | rnd | sticky;
        bump    = 1'b0;
        if (inexact) begin
            unique case (rnd_mode_e'(mode))
                RM_NEAREST: bump = guard & (rnd | sticky | mant[0]);
                RM_TOZERO:  bump = 1'b0;
                RM_DOWN:    bump = sign;
                RM_UP:      bump = ~sign;
                default:    bump = 1'b0;
            endcase
        end
    end

    // Add the increment with carry into the extra top bit.
    always_comb result = {1'b0, mant} + {{MANT_W{1'b0}}, bump};
endmodule

// File: rtl/sp_sat.sv
// Picks the word used when the exponent leaves the finite range.
// The choice is infinity or the largest finite magnitude of the same sign.
// Assumes: the mode encoding from sp_pkg.
module sp_sat
    import sp_pkg::*;
#(
    parameter int EXP_BITS = 8,
    parameter int FRAC_W   = 23
) (
    input  logic                          sign,
    input  logic [1:0]                    mode,
    output logic [EXP_BITS+FRAC_W:0]      word
);
    logic to_inf;

    // Infinity when rounding heads away from zero in this sign.
    always_comb begin
        unique case (rnd_mode_e'(mode))
            RM_NEAREST: to_inf = 1'b1;
            RM_TOZERO:  to_inf = 1'b0;
            RM_DOWN:    to_inf = sign;
            RM_UP:      to_inf = ~sign;
            default:    to_inf = 1'b1;
        endcase
    end

    // Assemble either saturation pattern.
    always_comb begin
        if (to_inf)
            word = {sign, {EXP_BITS{1'b1}}, {FRAC_W{1'b0}}};
        else
            word = {sign, {(EXP_BITS-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end
endmodule

// File: rtl/sp_packer.sv
// Packs an unpacked value into a single-precision word in one clock.
// The normal and underflow paths are rounded in parallel and one is picked.
// Flags are registered per result and also accumulated in a status register.
// Assumes: for numbers, in_sig[SIG_W-1] is the leading one.
module sp_packer
    import sp_pkg::*;
#(
    parameter int EXP_W    = 10,
    parameter int EXP_BITS = 8,
    parameter int FRAC_W   = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               in_class,
    input  logic                     in_sign,
    input  logic signed [EXP_W-1:0]  in_exp,
    input  logic [FRAC_W+2:0]        in_sig,
    input  logic                     in_sticky,
    input  logic [1:0]               rnd_mode,
    input  logic                     clr_status,
    output logic                     out_valid,
    output logic [EXP_BITS+FRAC_W:0] out_word,
    output logic [FLG_W-1:0]         out_flags,
    output logic [FLG_W-1:0]         status
);
    localparam int SIG_W  = FRAC_W + 3;
    localparam int MANT_W = FRAC_W + 1;
    localparam int WORD_W = EXP_BITS + FRAC_W + 1;
    localparam int BW     = EXP_W + 2;
    localparam int SH_MAX = SIG_W + 1;
    localparam int SH_W   = $clog2(SH_MAX + 1);
    localparam logic signed [BW-1:0] BIAS_S = BW'((1 << (EXP_BITS - 1)) - 1);
    localparam logic signed [BW-1:0] EMAX_S = BW'((1 << EXP_BITS) - 1);

    logic signed [BW-1:0] biased;
    logic signed [BW-1:0] exp_fin;
    logic signed [BW-1:0] sh_full;
    logic [SH_W-1:0]      shamt;
    logic                 is_sub;

    logic [SIG_W-1:0]     a_sig;
    logic                 a_sticky;
    logic [MANT_W:0]      res_n, res_s;
    logic                 inex_n, inex_s;
    logic [WORD_W-1:0]    sat_word;

    logic [WORD_W-1:0]    word_d;
    logic [FLG_W-1:0]     flags_d;

    // Rebias the exponent and pick the path.
    always_comb begin
        biased  = {{2{in_exp[EXP_W-1]}}, in_exp} + BIAS_S;
        is_sub  = (biased <= 0);
        sh_full = BW'(1) - biased;
        if (!is_sub)
            shamt = '0;
        else if (sh_full > BW'(SH_MAX))
            shamt = SH_W'(SH_MAX);
        else
            shamt = sh_full[SH_W-1:0];
    end

    sp_align #(.SIG_W(SIG_W), .SH_W(SH_W)) u_align (
        .sig_in     (in_sig),
        .sticky_in  (in_sticky),
        .shamt      (shamt),
        .sig_out    (a_sig),
        .sticky_out (a_sticky)
    );

    sp_round #(.MANT_W(MANT_W)) u_rnd_norm (
        .mant    (in_sig[SIG_W-1:2]),
        .guard   (in_sig[1]),
        .rnd     (in_sig[0]),
        .sticky  (in_sticky),
        .sign    (in_sign),
        .mode    (rnd_mode),
        .result  (res_n),
        .inexact (inex_n)
    );

    sp_round #(.MANT_W(MANT_W)) u_rnd_sub (
        .mant    (a_sig[SIG_W-1:2]),
        .guard   (a_sig[1]),
        .rnd     (a_sig[0]),
        .sticky  (a_sticky),
        .sign    (in_sign),
        .mode    (rnd_mode),
        .result  (res_s),
        .inexact (inex_s)
    );

    sp_sat #(.EXP_BITS(EXP_BITS), .FRAC_W(FRAC_W)) u_sat (
        .sign (in_sign),
        .mode (rnd_mode),
        .word (sat_word)
    );

    // Final exponent after a possible rounding carry.
    always_comb exp_fin = biased + $signed({{(BW-1){1'b0}}, res_n[MANT_W]});

    // Select the packed word and flags by class and path.
    always_comb begin
        word_d  = '0;
        flags_d = '0;
        unique case (val_class_e'(in_class))
            CLS_ZERO: word_d = {in_sign, {(WORD_W-1){1'b0}}};
            CLS_INF:  word_d = {in_sign, {EXP_BITS{1'b1}}, {FRAC_W{1'b0}}};
            CLS_NAN:  word_d = {in_sign, {EXP_BITS{1'b1}}, in_sig[SIG_W-2:2]};
            CLS_NUM: begin
                if (is_sub) begin
                    word_d = {in_sign, {(EXP_BITS-2){1'b0}}, res_s[MANT_W:FRAC_W],
                              res_s[FRAC_W-1:0]};
                    flags_d[FLG_UNFL] = 1'b1;
                    flags_d[FLG_INEX] = inex_s;
                end else if (exp_fin >= EMAX_S) begin
                    word_d = sat_word;
                    flags_d[FLG_OVFL]  = 1'b1;
                    flags_d[FLG_INEX]  = 1'b1;
                    flags_d[FLG_OPERR] = 1'b1;
                end else begin
                    word_d = {in_sign, exp_fin[EXP_BITS-1:0], res_n[FRAC_W-1:0]};
                    flags_d[FLG_INEX] = inex_n;
                end
            end
            default: word_d = '0;
        endcase
    end

    // Result register: one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word  <= word_d;
                out_flags <= flags_d;
            end
        end
    end

    // Sticky status: clear wipes history, this cycle's flags still land.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (clr_status ? '0 : status) | (in_valid ? flags_d : '0);
    end

    // R1: output valid follows input valid by one clock
    assert_valid_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R9: overflow always brings inexact and operand error
    assert_ovf_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[FLG_OVFL]) |-> (out_flags[FLG_INEX] && out_flags[FLG_OPERR]));

    // R7: underflow results never carry an exponent above the smallest normal
    assert_unfl_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[FLG_UNFL]) |-> (out_word[WORD_W-2:FRAC_W] <= EXP_BITS'(1)));

    // R10: toward-zero overflow never yields infinity
    assert_tz_no_inf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && out_flags[FLG_OVFL] && $past(rnd_mode) == RM_TOZERO)
        |-> (out_word[WORD_W-2:FRAC_W] == EXP_BITS'((1 << EXP_BITS) - 2)));

    // R11: without a clear, status bits never drop
    assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_status)) |-> ((status & $past(status)) == $past(status)));

endmodule

// File: tb/sp_packer_tb.sv
`timescale 1ns/1ps
module sp_packer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_class;
    logic        in_sign;
    logic signed [9:0] in_exp;
    logic [25:0] in_sig;
    logic        in_sticky;
    logic [1:0]  rnd_mode;
    logic        clr_status;
    logic        out_valid;
    logic [31:0] out_word;
    logic [3:0]  out_flags;
    logic [3:0]  status;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sp_packer u_dut (
        .clk, .rst_n, .in_valid, .in_class, .in_sign, .in_exp, .in_sig,
        .in_sticky, .rnd_mode, .clr_status, .out_valid, .out_word,
        .out_flags, .status
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [25:0] mk(logic [22:0] frac, logic [1:0] gr);
        return {1'b1, frac, gr};
    endfunction

    // Drive one operand at a falling edge and check its result at the next one.
    task automatic apply(string req, logic [1:0] cls, logic sg, int e,
                         logic [25:0] sig, logic st, logic [1:0] md, logic clr,
                         logic [31:0] exp_word, logic [3:0] exp_flags);
        in_valid = 1'b1; in_class = cls; in_sign = sg; in_exp = 10'(e);
        in_sig = sig; in_sticky = st; rnd_mode = md; clr_status = clr;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; clr_status = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " word"}, out_word, exp_word);
        check({req, " flags"}, {28'd0, out_flags}, {28'd0, exp_flags});
    endtask

    task automatic t_reset;
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset word", out_word, 32'd0);
        check("R1 reset status", {28'd0, status}, 32'd0);
    endtask

    task automatic t_specials;
        apply("R3 zero", 2'd0, 1'b1, 5, mk(23'h1, 2'b11), 1'b1, 2'd3, 1'b0, 32'h8000_0000, 4'b0000);
        apply("R3 inf", 2'd2, 1'b0, 0, mk(23'h0, 2'b00), 1'b0, 2'd1, 1'b0, 32'h7F80_0000, 4'b0000);
        apply("R2 nan", 2'd3, 1'b1, 0, {1'b1, 23'h412345, 2'b11}, 1'b1, 2'd0, 1'b0, 32'hFFC1_2345, 4'b0000);
    endtask

    task automatic t_normal;
        apply("R4 exact one", 2'd1, 1'b0, 0, mk(23'h0, 2'b00), 1'b0, 2'd0, 1'b0, 32'h3F80_0000, 4'b0000);
        apply("R4 R5 tie odd", 2'd1, 1'b0, 0, mk(23'h1, 2'b10), 1'b0, 2'd0, 1'b0, 32'h3F80_0002, 4'b0001);
        apply("R4 tie even", 2'd1, 1'b0, 0, mk(23'h2, 2'b10), 1'b0, 2'd0, 1'b0, 32'h3F80_0002, 4'b0001);
        apply("R4 toward zero", 2'd1, 1'b0, 0, mk(23'h5, 2'b11), 1'b0, 2'd1, 1'b0, 32'h3F80_0005, 4'b0001);
        apply("R4 down neg", 2'd1, 1'b1, 0, mk(23'h5, 2'b01), 1'b0, 2'd2, 1'b0, 32'hBF80_0006, 4'b0001);
        apply("R4 up neg", 2'd1, 1'b1, 0, mk(23'h5, 2'b01), 1'b0, 2'd3, 1'b0, 32'hBF80_0005, 4'b0001);
        apply("R5 sticky only", 2'd1, 1'b0, 0, mk(23'h5, 2'b00), 1'b1, 2'd3, 1'b0, 32'h3F80_0006, 4'b0001);
    endtask

    task automatic t_carry;
        apply("R6 carry bump", 2'd1, 1'b0, 0, mk(23'h7FFFFF, 2'b10), 1'b0, 2'd0, 1'b0, 32'h4000_0000, 4'b0001);
        apply("R6 R9 carry overflow", 2'd1, 1'b0, 127, mk(23'h7FFFFF, 2'b10), 1'b0, 2'd0, 1'b0, 32'h7F80_0000, 4'b1101);
    endtask

    task automatic t_overflow;
        apply("R9 R10 nearest", 2'd1, 1'b0, 128, mk(23'h0, 2'b00), 1'b0, 2'd0, 1'b0, 32'h7F80_0000, 4'b1101);
        apply("R10 toward zero", 2'd1, 1'b1, 128, mk(23'h0, 2'b00), 1'b0, 2'd1, 1'b0, 32'hFF7F_FFFF, 4'b1101);
        apply("R10 down pos", 2'd1, 1'b0, 128, mk(23'h0, 2'b00), 1'b0, 2'd2, 1'b0, 32'h7F7F_FFFF, 4'b1101);
        apply("R10 down neg", 2'd1, 1'b1, 128, mk(23'h0, 2'b00), 1'b0, 2'd2, 1'b0, 32'hFF80_0000, 4'b1101);
        apply("R10 up pos", 2'd1, 1'b0, 200, mk(23'h0, 2'b00), 1'b0, 2'd3, 1'b0, 32'h7F80_0000, 4'b1101);
    endtask

    task automatic t_subnormal;
        apply("R7 exact sub", 2'd1, 1'b0, -127, mk(23'h0, 2'b00), 1'b0, 2'd0, 1'b0, 32'h0040_0000, 4'b0010);
        apply("R7 R5 shifted out", 2'd1, 1'b0, -130, mk(23'h1, 2'b00), 1'b0, 2'd0, 1'b0, 32'h0008_0000, 4'b0011);
        apply("R7 up mode", 2'd1, 1'b0, -130, mk(23'h1, 2'b00), 1'b0, 2'd3, 1'b0, 32'h0008_0001, 4'b0011);
        apply("R8 promote", 2'd1, 1'b0, -127, mk(23'h7FFFFF, 2'b00), 1'b0, 2'd0, 1'b0, 32'h0080_0000, 4'b0011);
        apply("R7 deep nearest", 2'd1, 1'b0, -200, mk(23'h0, 2'b00), 1'b0, 2'd0, 1'b0, 32'h0000_0000, 4'b0011);
        apply("R7 deep down neg", 2'd1, 1'b1, -200, mk(23'h0, 2'b00), 1'b0, 2'd2, 1'b0, 32'h8000_0001, 4'b0011);
    endtask

    task automatic t_status;
        clr_status = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_status = 1'b0;
        check("R11 clear alone", {28'd0, status}, 32'd0);
        apply("R11 sub", 2'd1, 1'b0, -127, mk(23'h0, 2'b00), 1'b0, 2'd0, 1'b0, 32'h0040_0000, 4'b0010);
        check("R11 accum one", {28'd0, status}, 32'h2);
        apply("R11 ovf", 2'd1, 1'b0, 128, mk(23'h0, 2'b00), 1'b0, 2'd0, 1'b0, 32'h7F80_0000, 4'b1101);
        check("R11 accum two", {28'd0, status}, 32'hF);
        apply("R11 clear with flags", 2'd1, 1'b0, -130, mk(23'h1, 2'b00), 1'b0, 2'd0, 1'b1, 32'h0008_0000, 4'b0011);
        check("R11 clear same cycle", {28'd0, status}, 32'h3);
        @(posedge clk);
        @(negedge clk);
        check("R1 idle valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_class = 2'd0; in_sign = 1'b0;
        in_exp = '0; in_sig = '0; in_sticky = 1'b0; rnd_mode = 2'd0; clr_status = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_specials();
        t_normal();
        t_carry();
        t_overflow();
        t_subnormal();
        t_status();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule